// File: doc/BRIEF.md
# Infrared Carrier Frequency Sensor

This block measures the carrier on a raw infrared line, before any demodulation. The line is timed against a 2 MHz time base, which reaches the block as a clock-enable strobe, so one tick is 0.5 µs. The block measures the span from one rising edge of the line to the next, and the number of ticks the line is high inside that span. It collects a window of spans, averages them, and publishes three results. The first is an 8-bit period word: its upper bit says the result is valid and its lower seven bits hold the averaged span. The second is the averaged high time. The third, when the block is built with it, is the duty cycle in percent.

A host converts the results. The carrier frequency in hertz is 2,000,000 divided by the period field, and the duty cycle is the high time times 100 divided by the period field. A period field of zero means nothing has been measured. Measuring runs only while the detect-enable input is high. The host chooses the window length with a setting, and the usual setting is 99, which gives a window of 100 spans.

Top module: `ir_carrier_sense`

## Requirements
- R1: After reset, `prd_o`, `high_o` and `duty_o` are all zero, so the valid flag `prd_o[7]` is clear.
- R2: Each result is computed from spans measured in time-base ticks, from one rising edge of the line to the next, together with the high ticks inside each span. When the results are published, `prd_o[6:0]` holds the averaged span, `high_o` holds the averaged high time, and `prd_o[7]` is set.
- R3: A window holds `win_cfg_i`+1 spans. The setting is captured at the rising edge that opens the window. The published span is floor(sum of spans / (`win_cfg_i`+1)), and the published high time is averaged the same way.
- R4: `duty_o` = floor(`high_o` × 100 / `prd_o[6:0]`), taken from the same averaged values that are published with it.
- R5: While `det_en_i` is low, the valid flag is clear one cycle later and no new result is published. The count fields keep their last values.
- R6: After an enable, a window opens only on a rising edge that follows a low sample. A line that is already high when the block is enabled does not count as an edge.
- R7: A span longer than 127 ticks ends the window. The valid flag is cleared, the count fields stay unchanged, and a new window waits for the next rising edge. A span of exactly 127 ticks is accepted.
- R8: Counting advances only on cycles where `tick_en_i` is high, so results are in ticks at any strobe rate.
- R9: The valid flag is never set while the period field is zero.
- R10: Published results change only in a single publish cycle, all together. If `det_en_i` goes low while a finished window is still being divided, that result is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ir_raw_i | input | 1 | Raw infrared line, asynchronous to the clock |
| det_en_i | input | 1 | Carrier-detect enable |
| tick_en_i | input | 1 | 2 MHz time-base strobe (clock enable) |
| win_cfg_i | input | 8 | Window setting: the number of spans averaged, minus one |
| prd_o | output | 8 | Bit 7 is the valid flag; bits 6:0 hold the averaged span in ticks |
| high_o | output | 7 | Averaged high time in ticks |
| duty_o | output | 7 | Duty cycle in percent (zero when the duty stage is not built) |

## Verification
Two functions can coincide. A window can finish, and its averaged result still be in the serial divider, in the same cycle that detection is switched off. The bench counts the rising edges it drives on the line. It waits for the edge that closes a one-span window and lowers `det_en_i` four cycles later, which falls while the division is running. It then watches the valid flag for several hundred cycles and expects it to stay clear. After a re-enable it expects a correct fresh result. The square-wave vectors each have a known span and high time, and the bench compares every published field with the floor averages it computes itself.

// File: rtl/ircs_pkg.sv
package ircs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRD,
    SQ_HI,
    SQ_DUTY,
    SQ_PUB
  } seq_t;

  typedef enum logic {
    MT_ARM,
    MT_RUN
  } meter_t;

  localparam int unsigned PCT_SCALE = 100;
  localparam int unsigned PCT_W     = 7;

endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/ir_span_meter.sv
module ir_span_meter
  import ircs_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned CFG_W = 8,
  localparam int unsigned SUM_W = CNT_W + CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             done_o,
  output logic             abort_o,
  output logic [SUM_W-1:0] sum_prd_o,
  output logic [SUM_W-1:0] sum_hi_o,
  output logic [CFG_W:0]   len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meter_t           st_q, st_n;
  logic             prev_q, prev_n;
  logic [CNT_W-1:0] prd_q, prd_n;
  logic [CNT_W-1:0] hi_q, hi_n;
  logic [SUM_W-1:0] acc_prd_q, acc_prd_n;
  logic [SUM_W-1:0] acc_hi_q, acc_hi_n;
  logic [CFG_W-1:0] nper_q, nper_n;
  logic [CFG_W-1:0] len_q, len_n;
  logic             done_q, done_n;
  logic             abort_q, abort_n;
  logic [SUM_W-1:0] osum_prd_q, osum_prd_n;
  logic [SUM_W-1:0] osum_hi_q, osum_hi_n;
  logic [CFG_W:0]   olen_q, olen_n;

  logic             rise;
  logic [SUM_W-1:0] tot_prd;
  logic [SUM_W-1:0] tot_hi;

  assign rise    = tick_i && line_i && !prev_q;
  assign tot_prd = acc_prd_q + SUM_W'(prd_q);
  assign tot_hi  = acc_hi_q + SUM_W'(hi_q);

  always_comb begin
    st_n       = st_q;
    prev_n     = prev_q;
    prd_n      = prd_q;
    hi_n       = hi_q;
    acc_prd_n  = acc_prd_q;
    acc_hi_n   = acc_hi_q;
    nper_n     = nper_q;
    len_n      = len_q;
    done_n     = 1'b0;
    abort_n    = 1'b0;
    osum_prd_n = osum_prd_q;
    osum_hi_n  = osum_hi_q;
    olen_n     = olen_q;
    if (!en_i) begin
      st_n   = MT_ARM;
      prev_n = 1'b1;
    end else if (tick_i) begin
      prev_n = line_i;
      unique case (st_q)
        MT_ARM: begin
          if (rise) begin
            st_n      = MT_RUN;
            prd_n     = CNT_ONE;
            hi_n      = CNT_ONE;
            acc_prd_n = '0;
            acc_hi_n  = '0;
            nper_n    = '0;
            len_n     = cfg_i;
          end
        end
        MT_RUN: begin
          if (rise) begin
            prd_n = CNT_ONE;
            hi_n  = CNT_ONE;
            if (nper_q == len_q) begin
              done_n     = 1'b1;
              osum_prd_n = tot_prd;
              osum_hi_n  = tot_hi;
              olen_n     = {1'b0, len_q} + (CFG_W+1)'(1);
              acc_prd_n  = '0;
              acc_hi_n   = '0;
              nper_n     = '0;
              len_n      = cfg_i;
            end else begin
              acc_prd_n = tot_prd;
              acc_hi_n  = tot_hi;
              nper_n    = nper_q + CFG_W'(1);
            end
          end else if (prd_q == CNT_MAX) begin
            abort_n = 1'b1;
            st_n    = MT_ARM;
          end else begin
            prd_n = prd_q + CNT_ONE;
            hi_n  = hi_q + CNT_W'(line_i);
          end
        end
        default: st_n = MT_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= MT_ARM;
      prev_q     <= 1'b1;
      prd_q      <= '0;
      hi_q       <= '0;
      acc_prd_q  <= '0;
      acc_hi_q   <= '0;
      nper_q     <= '0;
      len_q      <= '0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
      osum_prd_q <= '0;
      osum_hi_q  <= '0;
      olen_q     <= '0;
    end else begin
      st_q       <= st_n;
      prev_q     <= prev_n;
      prd_q      <= prd_n;
      hi_q       <= hi_n;
      acc_prd_q  <= acc_prd_n;
      acc_hi_q   <= acc_hi_n;
      nper_q     <= nper_n;
      len_q      <= len_n;
      done_q     <= done_n;
      abort_q    <= abort_n;
      osum_prd_q <= osum_prd_n;
      osum_hi_q  <= osum_hi_n;
      olen_q     <= olen_n;
    end
  end

  assign done_o    = done_q;
  assign abort_o   = abort_q;
  assign sum_prd_o = osum_prd_q;
  assign sum_hi_o  = osum_hi_q;
  assign len_o     = olen_q;

  // R8: span counters only move on time-base ticks
  p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(prd_q) && $stable(hi_q));

  // R2: high time within a span never exceeds the span
  p_hi_in_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MT_RUN) |-> (hi_q <= prd_q));

  // R7: a window only ends abnormally after the span count reached its ceiling
  p_abort_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> ($past(prd_q) == CNT_MAX));

endmodule

// File: rtl/ir_serial_div.sv
module ir_serial_div #(
  parameter int unsigned W = 15,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  logic [W:0]    rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  den_q, den_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          done_q, done_n;

  logic [W:0] rem_sh;
  logic [W:0] diff;
  logic       ge;

  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};
  assign diff   = rem_sh - {1'b0, den_q};

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (clr_i) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (start_i) begin
      rem_n  = '0;
      quo_n  = num_i;
      den_n  = den_i;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n = ge ? diff : rem_sh;
      quo_n = {quo_q[W-2:0], ge};
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // R3: finished quotient leaves a remainder below the divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && den_q != '0) |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/ir_carrier_sense.sv
module ir_carrier_sense
  import ircs_pkg::*;
#(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned CFG_W   = 8,
  parameter bit          DUTY_EN = 1'b1,
  localparam int unsigned SUM_W  = CNT_W + CFG_W,
  localparam int unsigned MUL_W  = CNT_W + PCT_W,
  localparam int unsigned DIV_W  = (SUM_W > MUL_W) ? SUM_W : MUL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_raw_i,
  input  logic             det_en_i,
  input  logic             tick_en_i,
  input  logic [CFG_W-1:0] win_cfg_i,
  output logic [CNT_W:0]   prd_o,
  output logic [CNT_W-1:0] high_o,
  output logic [PCT_W-1:0] duty_o
);

  // reset: asserted at once, released through two flops
  logic rst_a_q, rst_b_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end

  logic line_s;
  ir_line_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_b_q),
    .d_i   (ir_raw_i),
    .q_o   (line_s)
  );

  logic             win_done, win_abort;
  logic [SUM_W-1:0] win_sum_prd, win_sum_hi;
  logic [CFG_W:0]   win_len;

  ir_span_meter #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_b_q),
    .en_i      (det_en_i),
    .tick_i    (tick_en_i),
    .line_i    (line_s),
    .cfg_i     (win_cfg_i),
    .done_o    (win_done),
    .abort_o   (win_abort),
    .sum_prd_o (win_sum_prd),
    .sum_hi_o  (win_sum_hi),
    .len_o     (win_len)
  );

  logic             div_clr, div_start, div_busy, div_done;
  logic [DIV_W-1:0] div_num, div_den, div_quot;

  ir_serial_div #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_b_q),
    .clr_i   (div_clr),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  seq_t             sq_q, sq_n;
  logic [CNT_W-1:0] pavg_q, pavg_n;
  logic [CNT_W-1:0] havg_q, havg_n;
  logic [PCT_W-1:0] pct_q, pct_n;
  logic [SUM_W-1:0] lat_hi_q, lat_hi_n;
  logic [CFG_W:0]   lat_len_q, lat_len_n;
  logic             val_q, val_n;
  logic [CNT_W-1:0] oprd_q, oprd_n;
  logic [CNT_W-1:0] ohi_q, ohi_n;
  logic [PCT_W-1:0] opct_q, opct_n;

  logic [CNT_W-1:0] q_cnt;
  logic [DIV_W-1:0] hi_scaled;

  assign q_cnt     = div_quot[CNT_W-1:0];
  assign hi_scaled = DIV_W'(havg_q) * DIV_W'(PCT_SCALE);

  always_comb begin
    sq_n      = sq_q;
    pavg_n    = pavg_q;
    havg_n    = havg_q;
    pct_n     = pct_q;
    lat_hi_n  = lat_hi_q;
    lat_len_n = lat_len_q;
    val_n     = val_q;
    oprd_n    = oprd_q;
    ohi_n     = ohi_q;
    opct_n    = opct_q;
    div_clr   = 1'b0;
    div_start = 1'b0;
    div_num   = DIV_W'(win_sum_prd);
    div_den   = DIV_W'(win_len);
    if (!det_en_i || win_abort) begin
      sq_n    = SQ_IDLE;
      val_n   = 1'b0;
      div_clr = 1'b1;
    end else begin
      unique case (sq_q)
        SQ_IDLE: begin
          if (win_done) begin
            div_start = 1'b1;
            lat_hi_n  = win_sum_hi;
            lat_len_n = win_len;
            sq_n      = SQ_PRD;
          end
        end
        SQ_PRD: begin
          if (div_done) begin
            pavg_n    = q_cnt;
            div_start = 1'b1;
            div_num   = DIV_W'(lat_hi_q);
            div_den   = DIV_W'(lat_len_q);
            sq_n      = SQ_HI;
          end
        end
        SQ_HI: begin
          if (div_done) begin
            havg_n = q_cnt;
            sq_n   = DUTY_EN ? SQ_DUTY : SQ_PUB;
          end
        end
        SQ_DUTY: begin
          if (!div_busy && !div_done) begin
            div_start = 1'b1;
            div_num   = hi_scaled;
            div_den   = DIV_W'(pavg_q);
          end else if (div_done) begin
            pct_n = div_quot[PCT_W-1:0];
            sq_n  = SQ_PUB;
          end
        end
        SQ_PUB: begin
          oprd_n = pavg_q;
          ohi_n  = havg_q;
          opct_n = pct_q;
          val_n  = (pavg_q != '0);
          sq_n   = SQ_IDLE;
        end
        default: sq_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_b_q) begin
    if (!rst_b_q) begin
      sq_q      <= SQ_IDLE;
      pavg_q    <= '0;
      havg_q    <= '0;
      pct_q     <= '0;
      lat_hi_q  <= '0;
      lat_len_q <= '0;
      val_q     <= 1'b0;
      oprd_q    <= '0;
      ohi_q     <= '0;
      opct_q    <= '0;
    end else begin
      sq_q      <= sq_n;
      pavg_q    <= pavg_n;
      havg_q    <= havg_n;
      pct_q     <= pct_n;
      lat_hi_q  <= lat_hi_n;
      lat_len_q <= lat_len_n;
      val_q     <= val_n;
      oprd_q    <= oprd_n;
      ohi_q     <= ohi_n;
      opct_q    <= opct_n;
    end
  end

  assign prd_o  = {val_q, oprd_q};
  assign high_o = ohi_q;

  if (DUTY_EN) begin : g_duty
    assign duty_o = opct_q;
  end else begin : g_noduty
    assign duty_o = '0;
  end

  // R5: detection off clears the valid flag on the next cycle
  p_clear_on_disable_r5: assert property (@(posedge clk) disable iff (!rst_b_q)
    !det_en_i |=> !prd_o[CNT_W]);

  // R9: a zero period is never reported as valid
  p_nonzero_valid_r9: assert property (@(posedge clk) disable iff (!rst_b_q)
    prd_o[CNT_W] |-> (prd_o[CNT_W-1:0] != '0));

  // R7: an oversize span drops the flag and keeps the count fields
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_b_q)
    win_abort |=> !prd_o[CNT_W] && $stable(prd_o[CNT_W-1:0]) && $stable(high_o));

  // R10: count fields move only in the publish cycle
  p_publish_only_r10: assert property (@(posedge clk) disable iff (!rst_b_q)
    (sq_q != SQ_PUB) |=> $stable(prd_o[CNT_W-1:0]) && $stable(high_o) && $stable(duty_o));

  // R4: a valid duty never exceeds 100 percent
  p_duty_range_r4: assert property (@(posedge clk) disable iff (!rst_b_q)
    prd_o[CNT_W] |-> (duty_o <= PCT_W'(PCT_SCALE)));

  // R3: averaged quotients fit the count field
  p_avg_fits_r3: assert property (@(posedge clk) disable iff (!rst_b_q)
    (div_done && (sq_q == SQ_PRD || sq_q == SQ_HI)) |-> (div_quot[DIV_W-1:CNT_W] == '0));

endmodule

// File: tb/test_ir_carrier_sense.sv
`timescale 1ns/1ps
module test_ir_carrier_sense;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ir_raw_i;
  logic       det_en_i;
  logic       tick_en_i;
  logic [7:0] win_cfg_i;
  logic [7:0] prd_o;
  logic [6:0] high_o;
  logic [6:0] duty_o;

  always #2 clk = ~clk;

  ir_carrier_sense i_ir_carrier_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_raw_i  (ir_raw_i),
    .det_en_i  (det_en_i),
    .tick_en_i (tick_en_i),
    .win_cfg_i (win_cfg_i),
    .prd_o     (prd_o),
    .high_o    (high_o),
    .duty_o    (duty_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // waveform generator, paced by the time-base strobe
  int g_p1 = 10, g_p2 = 10, g_h = 5, g_tdiv = 1, g_tcnt = 0;
  int g_pre_hi = 0, g_pre_lo = 0, g_phase = 0, g_cur = 10, g_rises = 0;
  bit g_on = 1'b0, g_idle = 1'b0, g_alt = 1'b0;

  always @(negedge clk) begin
    bit tk;
    bit nv;
    tk = (g_tcnt == 0);
    tick_en_i = tk;
    g_tcnt = (g_tcnt + 1 >= g_tdiv) ? 0 : g_tcnt + 1;
    if (!g_on) begin
      ir_raw_i = g_idle;
    end else if (tk) begin
      if (g_pre_hi > 0) begin
        nv = 1'b1; g_pre_hi--;
      end else if (g_pre_lo > 0) begin
        nv = 1'b0; g_pre_lo--;
      end else begin
        nv = (g_phase < g_h);
        g_phase++;
        if (g_phase >= g_cur) begin
          g_phase = 0;
          g_alt = !g_alt;
          g_cur = g_alt ? g_p2 : g_p1;
        end
      end
      if (nv && !ir_raw_i) g_rises++;
      ir_raw_i = nv;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic start_gen(input int p1, input int p2, input int h, input int tdiv, input int pre_hi);
    g_p1 = p1; g_p2 = p2; g_h = h; g_tdiv = tdiv; g_tcnt = 0;
    g_phase = 0; g_alt = 1'b0; g_cur = p1;
    g_pre_hi = pre_hi; g_pre_lo = 3; g_on = 1'b1;
  endtask

  task automatic stop_all();
    det_en_i = 1'b0;
    g_on = 1'b0;
    g_idle = 1'b0;
    step(6);
  endtask

  task automatic wait_valid(input int limit, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < limit; k++) begin
      step(1);
      if (prd_o[7]) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // stimulus/expectation table: window setting, span A, span B, high, tick divisor
  localparam int NV = 9;
  localparam int V_CFG [NV] = '{0, 3, 7, 0, 1, 5, 3, 99, 2};
  localparam int V_P1  [NV] = '{10, 52, 26, 127, 20, 2, 40, 53, 9};
  localparam int V_P2  [NV] = '{10, 52, 26, 127, 31, 2, 40, 53, 14};
  localparam int V_H   [NV] = '{5, 26, 9, 60, 7, 1, 30, 17, 4};
  localparam int V_TD  [NV] = '{1, 1, 1, 1, 1, 1, 2, 1, 3};

  int last_prd, last_hi;

  initial begin
    bit seen;
    int ep, eh, ed, n, sum, pmax, cnt_v, base;
    rst_n = 1'b0; det_en_i = 1'b0; win_cfg_i = 8'd0; ir_raw_i = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(5);
    // R1: reset state
    chk(prd_o == 8'h00, "R1 period word after reset", int'(prd_o), 0);
    chk(high_o == 7'd0, "R1 high after reset", int'(high_o), 0);
    chk(duty_o == 7'd0, "R1 duty after reset", int'(duty_o), 0);

    for (int v = 0; v < NV; v++) begin
      stop_all();
      // R5: valid clear while disabled
      chk(prd_o[7] == 1'b0, "R5 valid clear while disabled", int'(prd_o[7]), 0);
      n = V_CFG[v] + 1;
      sum = ((n + 1) / 2) * V_P1[v] + (n / 2) * V_P2[v];
      ep = sum / n;
      eh = V_H[v];
      ed = (eh * 100) / ep;
      pmax = (V_P1[v] > V_P2[v]) ? V_P1[v] : V_P2[v];
      win_cfg_i = 8'(V_CFG[v]);
      start_gen(V_P1[v], V_P2[v], V_H[v], V_TD[v], 0);
      det_en_i = 1'b1;
      wait_valid((n + 3) * pmax * V_TD[v] + 300, seen);
      chk(seen, "R2 valid flag raised", int'(seen), 1);
      // R2/R3/R8 averaged span; R4 duty
      chk(int'(prd_o[6:0]) == ep, "R3 averaged span (R2, R8)", int'(prd_o[6:0]), ep);
      chk(int'(high_o) == eh, "R2 averaged high time", int'(high_o), eh);
      chk(int'(duty_o) == ed, "R4 duty percent", int'(duty_o), ed);
      last_prd = ep;
      last_hi = eh;
    end

    // R5: count fields hold while disabled
    stop_all();
    chk(int'(prd_o[6:0]) == last_prd, "R5 span held when disabled", int'(prd_o[6:0]), last_prd);
    chk(int'(high_o) == last_hi, "R5 high held when disabled", int'(high_o), last_hi);

    // R7: span of 128 ticks never publishes
    win_cfg_i = 8'd0;
    start_gen(128, 128, 64, 1, 0);
    det_en_i = 1'b1;
    cnt_v = 0;
    for (int k = 0; k < 1300; k++) begin
      step(1);
      if (prd_o[7]) cnt_v++;
    end
    chk(cnt_v == 0, "R7 oversize span keeps valid clear", cnt_v, 0);
    chk(int'(prd_o[6:0]) == last_prd, "R7 span field unchanged", int'(prd_o[6:0]), last_prd);
    chk(int'(high_o) == last_hi, "R7 high field unchanged", int'(high_o), last_hi);

    // R6: line already high at enable is not an edge
    stop_all();
    g_idle = 1'b1;
    step(6);
    win_cfg_i = 8'd0;
    start_gen(10, 10, 5, 1, 20);
    det_en_i = 1'b1;
    wait_valid(400, seen);
    chk(seen && int'(prd_o[6:0]) == 10, "R6 first span after high line", int'(prd_o[6:0]), 10);

    // R10: disable lands while the finished window is being divided
    stop_all();
    win_cfg_i = 8'd0;
    base = g_rises;
    start_gen(10, 10, 5, 1, 0);
    det_en_i = 1'b1;
    while (g_rises < base + 2) step(1);
    step(4);
    det_en_i = 1'b0;
    cnt_v = 0;
    for (int k = 0; k < 400; k++) begin
      step(1);
      if (prd_o[7]) cnt_v++;
    end
    chk(cnt_v == 0, "R10 result discarded on disable", cnt_v, 0);
    det_en_i = 1'b1;
    wait_valid(400, seen);
    chk(seen && int'(prd_o[6:0]) == 10, "R10 fresh result after re-enable", int'(prd_o[6:0]), 10);
    // R9: valid implies nonzero period
    chk(!prd_o[7] || prd_o[6:0] != 7'd0, "R9 valid with nonzero span", int'(prd_o[6:0]), 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule